// File: doc/BRIEF.md
# Page Address Translation Unit

This block turns a 32-bit virtual address into a 32-bit physical address using 4 KB pages. The upper 20 address bits form the page number and the low 12 bits are the in-page offset, which passes through unchanged. Recent translations are kept in a small fully associative buffer of 8 entries. A request that finds its page there is answered one cycle after acceptance and makes no memory access.

When the page is missing, the unit runs a single-level table walk by itself. It reads one 32-bit table entry at the table base plus four times the page number. An entry whose valid flag is clear produces a page fault and is not kept. A valid entry is installed into the slot named by a round-robin pointer. It is then checked against the access kind, and a forbidden access produces a protection fault. Faulted responses carry a zero address.

A write that is allowed, to a page whose dirty flag is clear, is reported so that the table entry can be updated. Afterwards the buffered copy counts as dirty. A per-page invalidate input removes a buffered translation when the table changes.

Top module: `addr_xlate_unit`

## Requirements
- R1: Reset state: req_ready is 1, resp_valid and mem_rd_valid are 0, and the buffer is empty, so the first access to any page starts a table walk.
- R2: An accepted request whose page is buffered gives resp_valid exactly one cycle after acceptance, and mem_rd_valid stays 0.
- R3: On a miss, from the cycle after acceptance mem_rd_valid is 1 with mem_rd_addr = base + page number * 4, where base is the value of pt_base sampled at acceptance. Both hold until a cycle with mem_rd_done, and the response follows in the next cycle.
- R4: A successful translation gives resp_paddr = {frame, offset}, where the frame is table-entry bits 31:12 and the offset is virtual address bits 11:0.
- R5: A fetched entry with bit 0 (valid) at 0 gives resp_page_fault = 1, resp_prot_fault = 0 and resp_paddr = 0, and installs nothing, so the next access to that page walks again.
- R6: req_type encodes 0 read, 1 write, 2 execute and 3 reserved. Read needs entry bit 1, write needs bit 2 and execute needs bit 3, while code 3 is never allowed. A forbidden access gives resp_prot_fault = 1, resp_page_fault = 0 and resp_paddr = 0, and the valid entry is still installed.
- R7: The buffer holds 8 entries and fills them in round-robin order. After 8 installs, the ninth install replaces the oldest one, so that page walks again.
- R8: An allowed write to a page whose dirty flag (entry bit 4) is clear gives resp_dirty_set = 1. The buffered copy then counts as dirty, and a later write that hits the same page gives resp_dirty_set = 0.
- R9: A one-cycle pulse on inv_valid removes the buffered entry for inv_vpn, so the next access to that page walks.
- R10: An invalidate in the same cycle as a lookup of the same page makes that lookup a miss. An invalidate in the same cycle as mem_rd_done for the page being walked lets the response through but installs nothing.
- R11: While a walk is in progress, req_ready is 0 and resp_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address |
| req_type | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_ready | output | 1 | Unit can accept a request |
| pt_base | input | 32 | Page table base address |
| inv_valid | input | 1 | Invalidate one page translation |
| inv_vpn | input | 20 | Page number to invalidate |
| mem_rd_valid | output | 1 | Table entry read request |
| mem_rd_addr | output | 32 | Table entry byte address |
| mem_rd_done | input | 1 | Read data present |
| mem_rd_data | input | 32 | Fetched table entry |
| resp_valid | output | 1 | Response pulse |
| resp_paddr | output | 32 | Physical address, 0 on a fault |
| resp_page_fault | output | 1 | Entry not valid |
| resp_prot_fault | output | 1 | Access forbidden |
| resp_dirty_set | output | 1 | Dirty flag must be set in the table |

## Verification
An invalidate can land in the same cycle as a lookup of the same page, or in the same cycle as the install at the end of a walk. The bench provokes the first case by raising inv_valid together with req_valid for a page it has just buffered, and it expects a table read to appear. It provokes the second case by raising inv_valid in the cycle that mem_rd_done is driven. In that case it expects a normal response, and it expects the following access to the same page to walk again. A bench-side model of the buffer, with the same round-robin order, predicts hit or miss for every access across a sweep of pages and access kinds.

// File: rtl/xlate_pkg.sv
// Shared constants, access encoding and buffered-entry layout for the
// translation unit. Assumes the table entry is at least as wide as the frame
// number plus the low flag bits.
package xlate_pkg;
    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int PTE_W     = 32;
    localparam int TLB_N     = 8;
    localparam int VPN_W     = VA_W - PAGE_BITS;
    localparam int PFN_W     = PA_W - PAGE_BITS;
    localparam int PTE_SHIFT = $clog2(PTE_W / 8);
    localparam int IDX_W     = $clog2(TLB_N);
    localparam int ADDR_PAD  = PA_W - VPN_W - PTE_SHIFT;

    localparam int B_VALID = 0;
    localparam int B_RD    = 1;
    localparam int B_WR    = 2;
    localparam int B_EX    = 3;
    localparam int B_DIRTY = 4;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_t;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             rd;
        logic             wr;
        logic             ex;
        logic             dirty;
    } tlb_data_t;

    function automatic tlb_data_t unpack_pte(input logic [PTE_W-1:0] p);
        tlb_data_t d;
        d.pfn   = p[PTE_W-1 -: PFN_W];
        d.rd    = p[B_RD];
        d.wr    = p[B_WR];
        d.ex    = p[B_EX];
        d.dirty = p[B_DIRTY];
        return d;
    endfunction
endpackage

// File: rtl/xlate_perm.sv
// Permission check: decides whether an access kind is allowed by the flags
// of a translation. Purely combinational; the reserved kind is never allowed.
module xlate_perm
    import xlate_pkg::*;
(
    input  acc_t      acc,
    input  tlb_data_t ent,
    output logic      allow
);
    // Select the flag that governs this access kind.
    always_comb begin
        case (acc)
            ACC_READ:  allow = ent.rd;
            ACC_WRITE: allow = ent.wr;
            ACC_EXEC:  allow = ent.ex;
            default:   allow = 1'b0;
        endcase
    end
endmodule

// File: rtl/xlate_tlb.sv
// Fully associative translation buffer with round-robin installs, per-page
// invalidate and a dirty mark on hits. Assumes a filled page is never already
// present (fills only follow a miss). An invalidate of the looked-up or
// filled page in the same cycle wins over the hit or the install.
module xlate_tlb
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output tlb_data_t        lk_data,
    input  logic             mark_en,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  tlb_data_t        fill_data
);
    logic [TLB_N-1:0] ent_v;
    logic [VPN_W-1:0] ent_vpn [TLB_N];
    tlb_data_t        ent_d   [TLB_N];
    logic [IDX_W-1:0] ptr;
    logic [TLB_N-1:0] match;
    logic [TLB_N-1:0] kill;
    logic             fill_ok;

    assign fill_ok = fill_en && !(inv_valid && inv_vpn == fill_vpn);
    assign lk_hit  = (|match) && !(inv_valid && inv_vpn == lk_vpn);

    generate
        for (genvar i = 0; i < TLB_N; i++) begin : g_ent
            assign match[i] = ent_v[i] && ent_vpn[i] == lk_vpn;
            assign kill[i]  = inv_valid && ent_v[i] && ent_vpn[i] == inv_vpn;

            // Install, drop or mark dirty one buffer slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_v[i]   <= 1'b0;
                    ent_vpn[i] <= '0;
                    ent_d[i]   <= '0;
                end else if (fill_ok && ptr == IDX_W'(i)) begin
                    ent_v[i]   <= 1'b1;
                    ent_vpn[i] <= fill_vpn;
                    ent_d[i]   <= fill_data;
                end else if (kill[i]) begin
                    ent_v[i]   <= 1'b0;
                end else if (mark_en && match[i]) begin
                    ent_d[i].dirty <= 1'b1;
                end
            end
        end
    endgenerate

    // Merge the data of the (at most one) matching slot.
    always_comb begin
        lk_data = '0;
        for (int i = 0; i < TLB_N; i++) begin
            if (match[i]) lk_data = tlb_data_t'(lk_data | ent_d[i]);
        end
    end

    // Advance the replacement pointer on every real install.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr <= '0;
        else if (fill_ok) ptr <= (ptr == IDX_W'(TLB_N - 1)) ? '0 : ptr + 1'b1;
    end

    p_one_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));
endmodule

// File: rtl/xlate_walker.sv
// Table walk sequencer: holds the base and page number of a missed request,
// drives one entry read and waits for its completion. Assumes the memory
// side keeps the read request pending until it raises done.
module xlate_walker
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [VPN_W-1:0] start_vpn,
    input  logic [PA_W-1:0]  start_base,
    input  logic             mem_rd_done,
    output logic             walking,
    output logic [VPN_W-1:0] walk_vpn,
    output logic             mem_rd_valid,
    output logic [PA_W-1:0]  mem_rd_addr
);
    typedef enum logic {W_IDLE, W_READ} wstate_t;
    wstate_t         st;
    logic [PA_W-1:0] base_q;

    // Capture the walk context and track the outstanding read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= W_IDLE;
            base_q   <= '0;
            walk_vpn <= '0;
        end else if (st == W_IDLE && start) begin
            st       <= W_READ;
            base_q   <= start_base;
            walk_vpn <= start_vpn;
        end else if (st == W_READ && mem_rd_done) begin
            st       <= W_IDLE;
        end
    end

    assign walking      = (st == W_READ);
    assign mem_rd_valid = walking;
    assign mem_rd_addr  = base_q + {{ADDR_PAD{1'b0}}, walk_vpn, {PTE_SHIFT{1'b0}}};

    p_hold_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_done) |=> (mem_rd_valid && $stable(mem_rd_addr)));
endmodule

// File: rtl/addr_xlate_unit.sv
// Address translation unit: buffered lookup, automatic single-level walk on
// a miss, validity and permission checks, dirty reporting and invalidation.
// Assumes one request at a time; requests are held off during a walk.
module addr_xlate_unit
    import xlate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_type,
    output logic             req_ready,
    input  logic [PA_W-1:0]  pt_base,
    input  logic             inv_valid,
    input  logic [VPN_W-1:0] inv_vpn,
    output logic             mem_rd_valid,
    output logic [PA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_done,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic             resp_page_fault,
    output logic             resp_prot_fault,
    output logic             resp_dirty_set
);
    logic                 walking, accept, lk_hit, allow_h, allow_w;
    logic                 walk_end, pte_ok, fill_en, mark_en;
    logic [VPN_W-1:0]     vpn_in, walk_vpn;
    logic [PAGE_BITS-1:0] off_in, off_q;
    acc_t                 acc_in, acc_q;
    tlb_data_t            lk_data, pte_d, fill_data;

    assign vpn_in    = req_vaddr[VA_W-1:PAGE_BITS];
    assign off_in    = req_vaddr[PAGE_BITS-1:0];
    assign acc_in    = acc_t'(req_type);
    assign req_ready = !walking;
    assign accept    = req_valid && req_ready;
    assign walk_end  = walking && mem_rd_done;
    assign pte_ok    = mem_rd_data[B_VALID];
    assign pte_d     = unpack_pte(mem_rd_data);
    assign fill_en   = walk_end && pte_ok;
    assign mark_en   = accept && lk_hit && acc_in == ACC_WRITE && allow_h;

    // The installed copy is dirty once an allowed write has used it.
    always_comb begin
        fill_data       = pte_d;
        fill_data.dirty = pte_d.dirty | (acc_q == ACC_WRITE && allow_w);
    end

    xlate_tlb u_tlb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_vpn    (vpn_in),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data),
        .mark_en   (mark_en),
        .inv_valid (inv_valid),
        .inv_vpn   (inv_vpn),
        .fill_en   (fill_en),
        .fill_vpn  (walk_vpn),
        .fill_data (fill_data)
    );

    xlate_walker u_walk (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept && !lk_hit),
        .start_vpn    (vpn_in),
        .start_base   (pt_base),
        .mem_rd_done  (mem_rd_done),
        .walking      (walking),
        .walk_vpn     (walk_vpn),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_addr  (mem_rd_addr)
    );

    xlate_perm u_perm_hit  (.acc(acc_in), .ent(lk_data), .allow(allow_h));
    xlate_perm u_perm_walk (.acc(acc_q),  .ent(pte_d),   .allow(allow_w));

    // Keep the offset and access kind of the request under walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_q <= '0;
            acc_q <= ACC_READ;
        end else if (accept) begin
            off_q <= off_in;
            acc_q <= acc_in;
        end
    end

    // Form the one-cycle response from a hit or from a finished walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid      <= 1'b0;
            resp_paddr      <= '0;
            resp_page_fault <= 1'b0;
            resp_prot_fault <= 1'b0;
            resp_dirty_set  <= 1'b0;
        end else if (accept && lk_hit) begin
            resp_valid      <= 1'b1;
            resp_paddr      <= allow_h ? {lk_data.pfn, off_in} : '0;
            resp_page_fault <= 1'b0;
            resp_prot_fault <= !allow_h;
            resp_dirty_set  <= allow_h && acc_in == ACC_WRITE && !lk_data.dirty;
        end else if (walk_end) begin
            resp_valid      <= 1'b1;
            resp_paddr      <= (pte_ok && allow_w) ? {pte_d.pfn, off_q} : '0;
            resp_page_fault <= !pte_ok;
            resp_prot_fault <= pte_ok && !allow_w;
            resp_dirty_set  <= pte_ok && allow_w && acc_q == ACC_WRITE && !pte_d.dirty;
        end else begin
            resp_valid      <= 1'b0;
            resp_paddr      <= '0;
            resp_page_fault <= 1'b0;
            resp_prot_fault <= 1'b0;
            resp_dirty_set  <= 1'b0;
        end
    end

    p_walk_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (!req_ready && !resp_valid));
    p_fault_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !(resp_page_fault && resp_prot_fault));
    p_fault_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && (resp_page_fault || resp_prot_fault)) |-> (resp_paddr == '0 && !resp_dirty_set));
    p_walk_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_valid) |-> $past(req_valid && req_ready));
endmodule

// File: tb/addr_xlate_unit_test.sv
// Self-checking bench: sweeps pages and access kinds against a bench model
// of the buffer and a computed page table, then targets eviction, faults,
// dirty reporting, invalidation and same-cycle collisions.
module addr_xlate_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] PTBASE = 32'h0010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_type = '0;
    logic        req_ready;
    logic [31:0] pt_base = PTBASE;
    logic        inv_valid = 1'b0;
    logic [19:0] inv_vpn = '0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_done = 1'b0;
    logic [31:0] mem_rd_data = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_page_fault, resp_prot_fault, resp_dirty_set;

    int checks = 0;
    int failures = 0;

    logic [19:0] m_vpn [8];
    bit          m_v   [8];
    bit          m_d   [8];
    int          m_ptr = 0;

    addr_xlate_unit uut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Page table content: [31:12] frame, [4] dirty, [3] exec, [2] write, [1] read, [0] valid.
    function automatic logic [31:0] pte_of(input logic [19:0] v);
        return {v ^ 20'h5A5A5, 7'b0, v[7], v[6], v[5], v[4] | ~v[5], v[2:0] != 3'd5};
    endfunction

    function automatic int find(input logic [19:0] v);
        for (int i = 0; i < 8; i++) if (m_v[i] && m_vpn[i] == v) return i;
        return -1;
    endfunction

    function automatic void model_inv(input logic [19:0] v);
        int k;
        k = find(v);
        if (k >= 0) m_v[k] = 0;
    endfunction

    task automatic do_inv(input logic [19:0] v);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        inv_valid = 1'b1;
        inv_vpn   = v;
        model_inv(v);
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic access(input logic [31:0] va, input logic [1:0] t, input bit inv_req,
                          input bit inv_fill, input int dly, input string wtag);
        logic [19:0] v;
        logic [31:0] p;
        int  k, n;
        bit  saw, allow, valid, dirty;
        logic [31:0] exp_pa;
        v = va[31:12];
        while (!req_ready) @(negedge clk);
        if (inv_req) model_inv(v);
        k = find(v);
        p = pte_of(v);
        valid = (k < 0) ? p[0] : 1'b1;
        dirty = (k < 0) ? p[4] : m_d[k];
        case (t)
            2'd0: allow = p[1];
            2'd1: allow = p[2];
            2'd2: allow = p[3];
            default: allow = 1'b0;
        endcase
        exp_pa = (valid && allow) ? {p[31:12], va[11:0]} : 32'h0;
        req_valid = 1'b1; req_vaddr = va; req_type = t;
        if (inv_req) begin inv_valid = 1'b1; inv_vpn = v; end
        @(negedge clk);
        req_valid = 1'b0; inv_valid = 1'b0;
        saw = 0; n = 0;
        while (!resp_valid && n < 60) begin
            if (mem_rd_valid) begin
                saw = 1;
                chk("R3 table address", mem_rd_addr, PTBASE + {10'b0, v, 2'b00});
                chk("R11 ready low in walk", {31'b0, req_ready}, 32'h0);
                repeat (dly) @(negedge clk);
                chk("R3 address held", mem_rd_addr, PTBASE + {10'b0, v, 2'b00});
                mem_rd_done = 1'b1;
                mem_rd_data = p;
                if (inv_fill) begin inv_valid = 1'b1; inv_vpn = v; end
                @(negedge clk);
                mem_rd_done = 1'b0; inv_valid = 1'b0;
            end else begin
                @(negedge clk);
                n++;
            end
        end
        chk("R2 response seen", {31'b0, resp_valid}, 32'h1);
        chk({wtag, " walk taken"}, {31'b0, saw}, {31'b0, k < 0});
        chk("R4 physical address", resp_paddr, exp_pa);
        chk("R5 page fault", {31'b0, resp_page_fault}, {31'b0, !valid});
        chk("R6 protection fault", {31'b0, resp_prot_fault}, {31'b0, valid && !allow});
        chk("R8 dirty report", {31'b0, resp_dirty_set},
            {31'b0, valid && allow && t == 2'd1 && !dirty});
        if (k < 0 && valid && !inv_fill) begin
            m_v[m_ptr] = 1; m_vpn[m_ptr] = v;
            m_d[m_ptr] = p[4] | (t == 2'd1 && allow);
            m_ptr = (m_ptr + 1) % 8;
        end else if (k >= 0 && t == 2'd1 && allow) begin
            m_d[k] = 1;
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin m_v[i] = 0; m_d[i] = 0; m_vpn[i] = '0; end
        repeat (3) @(negedge clk);
        chk("R1 resp_valid at reset", {31'b0, resp_valid}, 32'h0);
        chk("R1 mem_rd_valid at reset", {31'b0, mem_rd_valid}, 32'h0);
        chk("R1 req_ready at reset", {31'b0, req_ready}, 32'h1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", {31'b0, req_ready}, 32'h1);
        access(32'h0000_3123, 2'd0, 0, 0, 0, "R1");

        // Sweep pages and access kinds, with repeats to hit the buffer.
        for (int v = 0; v < 40; v++) begin
            for (int t = 0; t < 4; t++) begin
                access({v[19:0], 12'((v * 37 + t * 511) & 12'hFFF)}, 2'(t), 0, 0, v % 3, "R2");
            end
        end

        // Round-robin eviction: nine distinct valid pages, then revisit.
        for (int k = 0; k < 9; k++) access({20'(200 + 8 * k), 12'h010}, 2'd0, 0, 0, 1, "R7");
        access({20'd200, 12'h020}, 2'd0, 0, 0, 0, "R7");
        access({20'd216, 12'h030}, 2'd0, 0, 0, 0, "R7");
        access({20'd208, 12'h040}, 2'd0, 0, 0, 0, "R7");

        // Invalid entry is never kept.
        access({20'd5, 12'h001}, 2'd0, 0, 0, 0, "R5");
        access({20'd5, 12'h002}, 2'd0, 0, 0, 2, "R5");

        // Dirty reporting on the walk path and on the hit path.
        access({20'h00020, 12'h100}, 2'd1, 0, 0, 0, "R8");
        access({20'h00020, 12'h104}, 2'd1, 0, 0, 0, "R8");
        access({20'h00021, 12'h200}, 2'd0, 0, 0, 0, "R8");
        access({20'h00021, 12'h204}, 2'd1, 0, 0, 0, "R8");
        access({20'h00021, 12'h208}, 2'd1, 0, 0, 0, "R8");

        // Protection: execute on a non-executable page, reserved kind.
        access({20'h00010, 12'h00C}, 2'd2, 0, 0, 0, "R6");
        access({20'h00010, 12'h00C}, 2'd3, 0, 0, 0, "R6");

        // Invalidate by page.
        access({20'h00040, 12'h300}, 2'd0, 0, 0, 0, "R9");
        access({20'h00040, 12'h300}, 2'd0, 0, 0, 0, "R9");
        do_inv(20'h00040);
        access({20'h00040, 12'h304}, 2'd0, 0, 0, 0, "R9");

        // Same-cycle collisions.
        access({20'h00041, 12'h010}, 2'd0, 0, 0, 0, "R10");
        access({20'h00041, 12'h014}, 2'd0, 1, 0, 0, "R10");
        access({20'h00042, 12'h020}, 2'd0, 0, 1, 1, "R10");
        access({20'h00042, 12'h024}, 2'd0, 0, 0, 0, "R10");
        access({20'h00042, 12'h028}, 2'd0, 0, 0, 0, "R10");

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule